// File: doc/BRIEF.md
# DS3 Data-Link HDLC Receiver

This block recovers bit-oriented HDLC frames from the data-link overhead of a DS3 signal. Upstream logic extracts the three data-link bits of the chosen subframe in every M-frame and presents them one at a time with a strobe. Between strobes the block holds its state completely, so a stream that delivers only three bits per M-frame is handled the same way as a dense one.

Inside a frame the receiver hunts for the flag octet and deletes inserted zeros. It packs the recovered bits into octets, least significant bit first, and writes each octet into a fixed window of an external message RAM through a plain write port. The window starts at address 0x0DE. When a frame closes, the block reports whether the CRC-16 check passed, how many octets were stored, the command/response bit, and a message-type octet taken from the header. An abort sequence or a full window discards the frame in progress, and the receiver goes back to flag hunting.

Top module: `dl_hdlc_rx`

## Requirements
- R1: The receiver changes state, and produces a write or a status pulse, only on a clock edge where `bit_vld` is high. `bit_in` is ignored while `bit_vld` is low.
- R2: Each received 0,1,1,1,1,1,1,0 sequence pulses `flag_seen` for one cycle, on the cycle after the edge that samples its final zero. This holds whether the receiver is hunting or inside a frame. A flag opens a new frame.
- R3: Inside a frame, a zero that follows five consecutive ones is deleted and is not part of the payload.
- R4: Payload octets are assembled least significant bit first. Each one is written (`wr_en` high for one cycle) to consecutive addresses starting at 0x0DE. The index restarts at 0x0DE after every flag, including a flag that both closes one frame and opens the next.
- R5: The window ends at 0x135 (88 octets). An 89th octet is not written, and the receiver returns to hunting without reporting end of message. The next flag opens a fresh frame at 0x0DE.
- R6: The CRC is CRC-16 with reflected polynomial 0x8408, preset 0xFFFF, computed over all stored bits including the two check octets. The check passes when the remainder equals 0xF0B8. At end of message, `fcs_err` is set if the check fails or if the frame did not end on an octet boundary. `fcs_err` holds until the next end of message.
- R7: Seven consecutive ones inside a frame pulse `abort_seen` once. The frame is discarded (no end of message) and the receiver hunts. Ones received while hunting raise no abort.
- R8: A closing flag pulses `msg_end` (in the same cycle as `flag_seen`) when the frame holds at least one payload bit. Consecutive flags with nothing between them give no `msg_end`.
- R9: At end of message, `cr_bit` takes bit 1 of the first stored octet. `msg_type` takes the fourth stored octet, or zero if fewer than four octets were stored. Both hold until the next end of message.
- R10: At end of message, `msg_len` reports the number of octets stored for that frame, including the two check octets. It holds until the next end of message.
- R11: While `rst` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe marking a data-link bit on `bit_in` |
| bit_in | input | 1 | Serial data-link bit |
| wr_en | output | 1 | Message RAM write enable |
| wr_addr | output | ADDR_W (9) | Message RAM write address |
| wr_data | output | 8 | Message RAM write data |
| flag_seen | output | 1 | One-cycle pulse per detected flag |
| abort_seen | output | 1 | One-cycle pulse per abort inside a frame |
| msg_end | output | 1 | One-cycle end-of-message pulse |
| fcs_err | output | 1 | Check failure of the last message |
| cr_bit | output | 1 | Command/response bit of the last message |
| msg_type | output | 8 | Fourth octet of the last message |
| msg_len | output | 7 | Octets stored for the last message |

## Verification
A single flag can end one frame and begin the next. On that one strobe the block must report end of message with the old frame's CRC, length and header, and must also rewind the write index and preset the CRC for the new frame. The bench provokes this by sending two frames separated by exactly one flag, the second with a corrupted check field. The per-cycle reference model judges the `msg_end`/`flag_seen` cycle and the status values latched there. Directed checks confirm that the second frame's first octet lands at 0x0DE and that its own check fails independently of the first.

// File: rtl/dl_hdlc_pkg.sv
`timescale 1ns/1ps
package dl_hdlc_pkg;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } rx_state_e;

  // per-strobe classification of the incoming bit
  typedef struct packed {
    logic emit;   // bit belongs to the candidate payload
    logic dbit;   // value of that bit
    logic flag;   // flag octet completed
    logic abort;  // seventh consecutive one
  } dl_evt_t;

  localparam int unsigned RUN_W      = 3;
  localparam int unsigned STUFF_RUN  = 5;
  localparam int unsigned FLAG_RUN   = 6;
  localparam int unsigned ABORT_RUN  = 7;
  // bits of a flag that look like data before the flag is recognised
  localparam int unsigned HOLD_BITS  = 6;

  localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [15:0] CRC_GOOD      = 16'hF0B8;

  localparam int unsigned CR_BIT_POS = 1;
  localparam int unsigned TYPE_IDX   = 3;

endpackage

// File: rtl/dl_bit_deframe.sv
`timescale 1ns/1ps
module dl_bit_deframe
  import dl_hdlc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    bit_vld,
  input  logic    bit_in,
  output dl_evt_t evt
);

  logic [RUN_W-1:0] run_q;

  always_comb begin
    evt.emit  = bit_vld && (run_q < RUN_W'(STUFF_RUN));
    evt.dbit  = bit_in;
    evt.flag  = bit_vld && !bit_in && (run_q == RUN_W'(FLAG_RUN));
    evt.abort = bit_vld &&  bit_in && (run_q == RUN_W'(FLAG_RUN));
  end

  // count of consecutive ones, saturating at the abort length
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (bit_vld) begin
      if (!bit_in) begin
        run_q <= '0;
      end else if (run_q != RUN_W'(ABORT_RUN)) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dl_emit_hold.sv
`timescale 1ns/1ps
module dl_emit_hold #(
  parameter int unsigned LEN = 6,
  localparam int unsigned FILL_W = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic push,
  input  logic din,
  output logic out_vld,
  output logic out_bit
);

  logic [LEN-1:0]    sh_q;
  logic [FILL_W-1:0] fill_q;
  logic              full;

  assign full    = (fill_q == FILL_W'(LEN));
  assign out_vld = push && !clr && full;
  assign out_bit = sh_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (clr) begin
      fill_q <= '0;
    end else if (push) begin
      sh_q <= {din, sh_q[LEN-1:1]};
      if (!full) begin
        fill_q <= fill_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dl_crc16_chk.sv
`timescale 1ns/1ps
module dl_crc16_chk
  import dl_hdlc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic ok
);

  logic [15:0] crc_q;
  logic [15:0] crc_d;

  always_comb begin
    crc_d = {1'b0, crc_q[15:1]};
    if (crc_q[0] ^ din) begin
      crc_d = crc_d ^ CRC_POLY_REFL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_q <= CRC_PRESET;
    end else if (en) begin
      crc_q <= crc_d;
    end
  end

  assign ok = (crc_q == CRC_GOOD);

endmodule

// File: rtl/dl_octet_pack.sv
`timescale 1ns/1ps
module dl_octet_pack #(
  parameter int unsigned W = 8,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic         done,
  output logic [W-1:0] octet,
  output logic         partial
);

  logic [W-2:0]  sh_q;
  logic [CW-1:0] cnt_q;

  assign done    = en && (cnt_q == CW'(W - 1));
  assign octet   = {din, sh_q};
  assign partial = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (en) begin
      sh_q  <= {din, sh_q[W-2:1]};
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/dl_hdlc_rx.sv
`timescale 1ns/1ps
module dl_hdlc_rx
  import dl_hdlc_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'('h0DE),
  parameter logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'('h135),
  parameter int unsigned OCTET_W = 8,
  localparam int unsigned DEPTH = 32'(LAST_ADDR) - 32'(BASE_ADDR) + 32'd1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_vld,
  input  logic               bit_in,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [OCTET_W-1:0] wr_data,
  output logic               flag_seen,
  output logic               abort_seen,
  output logic               msg_end,
  output logic               fcs_err,
  output logic               cr_bit,
  output logic [OCTET_W-1:0] msg_type,
  output logic [CNT_W-1:0]   msg_len
);

  rx_state_e          state_q;
  dl_evt_t            evt;
  logic               in_frame;
  logic               push;
  logic               hold_vld;
  logic               hold_bit;
  logic               octet_done;
  logic [OCTET_W-1:0] octet;
  logic               partial;
  logic               crc_ok;
  logic               closing;
  logic               window_full;
  logic [CNT_W-1:0]   cnt_q;
  logic               hdr_cr_q;
  logic [OCTET_W-1:0] hdr_type_q;

  assign in_frame    = (state_q == ST_FRAME);
  assign push        = in_frame && evt.emit;
  assign window_full = (cnt_q == CNT_W'(DEPTH));
  assign closing     = in_frame && evt.flag && ((cnt_q != '0) || partial);

  dl_bit_deframe u_deframe (
    .clk     (clk),
    .rst     (rst),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .evt     (evt)
  );

  dl_emit_hold #(.LEN(HOLD_BITS)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .clr     (evt.flag),
    .push    (push),
    .din     (evt.dbit),
    .out_vld (hold_vld),
    .out_bit (hold_bit)
  );

  dl_crc16_chk u_crc (
    .clk (clk),
    .rst (rst),
    .clr (evt.flag),
    .en  (hold_vld),
    .din (hold_bit),
    .ok  (crc_ok)
  );

  dl_octet_pack #(.W(OCTET_W)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .clr     (evt.flag),
    .en      (hold_vld),
    .din     (hold_bit),
    .done    (octet_done),
    .octet   (octet),
    .partial (partial)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_HUNT;
      cnt_q      <= '0;
      hdr_cr_q   <= 1'b0;
      hdr_type_q <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      flag_seen  <= 1'b0;
      abort_seen <= 1'b0;
      msg_end    <= 1'b0;
      fcs_err    <= 1'b0;
      cr_bit     <= 1'b0;
      msg_type   <= '0;
      msg_len    <= '0;
    end else begin
      wr_en      <= 1'b0;
      flag_seen  <= 1'b0;
      abort_seen <= 1'b0;
      msg_end    <= 1'b0;
      if (evt.flag) begin
        flag_seen <= 1'b1;
        if (closing) begin
          msg_end  <= 1'b1;
          fcs_err  <= !crc_ok || partial;
          msg_len  <= cnt_q;
          cr_bit   <= hdr_cr_q;
          msg_type <= (cnt_q > CNT_W'(TYPE_IDX)) ? hdr_type_q : '0;
        end
        state_q    <= ST_FRAME;
        cnt_q      <= '0;
        hdr_cr_q   <= 1'b0;
        hdr_type_q <= '0;
      end else if (in_frame && evt.abort) begin
        abort_seen <= 1'b1;
        state_q    <= ST_HUNT;
      end else if (octet_done) begin
        if (window_full) begin
          state_q <= ST_HUNT;
        end else begin
          wr_en   <= 1'b1;
          wr_addr <= BASE_ADDR + ADDR_W'(cnt_q);
          wr_data <= octet;
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == '0) begin
            hdr_cr_q <= octet[CR_BIT_POS];
          end
          if (cnt_q == CNT_W'(TYPE_IDX)) begin
            hdr_type_q <= octet;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dl_hdlc_rx_chk.sv
`timescale 1ns/1ps
module dl_hdlc_rx_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'('h0DE),
  parameter logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'('h135),
  parameter int unsigned DEPTH = 88,
  parameter int unsigned CNT_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_vld,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              flag_seen,
  input logic              abort_seen,
  input logic              msg_end,
  input logic              fcs_err,
  input logic              cr_bit,
  input logic [CNT_W-1:0]  msg_len
);

  // R1: every event follows a strobed bit
  assert_gated_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en || msg_end || flag_seen || abort_seen) |-> $past(bit_vld));

  // R4 / R5: writes stay inside the message window
  assert_wr_window_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr >= BASE_ADDR && wr_addr <= LAST_ADDR));

  // R8: end of message only on a flag
  assert_eom_on_flag_R8: assert property (@(posedge clk) disable iff (rst)
    msg_end |-> flag_seen);

  // R7: abort excludes flag, write and end of message
  assert_abort_alone_R7: assert property (@(posedge clk) disable iff (rst)
    abort_seen |-> (!flag_seen && !msg_end && !wr_en));

  // R6: check status holds between messages
  assert_fcs_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !msg_end |-> $stable(fcs_err));

  // R9: header status holds between messages
  assert_cr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !msg_end |-> $stable(cr_bit));

  // R10: reported length fits the window
  assert_len_bound_R10: assert property (@(posedge clk) disable iff (rst)
    msg_end |-> (32'(msg_len) <= DEPTH));

  // R4: no write in the cycle of a flag
  assert_no_wr_on_flag_R4: assert property (@(posedge clk) disable iff (rst)
    flag_seen |-> !wr_en);

endmodule

bind dl_hdlc_rx dl_hdlc_rx_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .LAST_ADDR (LAST_ADDR),
  .DEPTH     (DEPTH),
  .CNT_W     (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_vld    (bit_vld),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .flag_seen  (flag_seen),
  .abort_seen (abort_seen),
  .msg_end    (msg_end),
  .fcs_err    (fcs_err),
  .cr_bit     (cr_bit),
  .msg_len    (msg_len)
);

// File: tb/dl_hdlc_rx_tb.sv
`timescale 1ns/1ps
module dl_hdlc_rx_tb;

  localparam int BASE  = 'h0DE;
  localparam int DEPTH = 88;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b0;
  logic       wr_en;
  logic [8:0] wr_addr;
  logic [7:0] wr_data;
  logic       flag_seen, abort_seen, msg_end, fcs_err, cr_bit;
  logic [7:0] msg_type;
  logic [6:0] msg_len;

  always #2.5 clk = ~clk;

  dl_hdlc_rx u_dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_seen(flag_seen), .abort_seen(abort_seen), .msg_end(msg_end),
    .fcs_err(fcs_err), .cr_bit(cr_bit), .msg_type(msg_type), .msg_len(msg_len)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int        m_ones, m_stored, m_nb;
  bit        m_in;
  bit [7:0]  m_acc, m_h0, m_h3;
  bit [15:0] m_crc;
  bit        m_pend[$];
  // expected outputs
  bit        e_wr_en, e_flag, e_abort, e_end, e_fcs, e_cr;
  int        e_addr, e_data, e_type, e_len;

  // bench observation
  bit [7:0] mem [0:511];
  int wr_total, eom_total, abort_total, flag_total, last_wr_addr;
  int gap_ctr, tx_ones;

  function automatic bit [15:0] crc_step(input bit [15:0] c, input bit b);
    bit [15:0] n;
    n = c >> 1;
    if (c[0] ^ b) n = n ^ 16'h8408;
    return n;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic m_take(input bit b);
    m_crc = crc_step(m_crc, b);
    m_acc[m_nb] = b;
    m_nb++;
    if (m_nb == 8) begin
      m_nb = 0;
      if (m_stored == DEPTH) begin
        m_in = 0;
      end else begin
        e_wr_en = 1;
        e_addr  = BASE + m_stored;
        e_data  = m_acc;
        if (m_stored == 0) m_h0 = m_acc;
        if (m_stored == 3) m_h3 = m_acc;
        m_stored++;
      end
    end
  endtask

  task automatic m_emit(input bit b);
    if (!m_in) return;
    m_pend.push_back(b);
    if (m_pend.size() > 6) m_take(m_pend.pop_front());
  endtask

  task automatic m_flag();
    e_flag = 1;
    if (m_in && (m_stored > 0 || m_nb > 0)) begin
      e_end  = 1;
      e_fcs  = (m_crc != 16'hF0B8) || (m_nb != 0);
      e_len  = m_stored;
      e_cr   = m_h0[1];
      e_type = (m_stored >= 4) ? m_h3 : 0;
    end
    m_in = 1; m_pend.delete(); m_nb = 0; m_acc = 0;
    m_crc = 16'hFFFF; m_stored = 0; m_h0 = 0; m_h3 = 0;
  endtask

  task automatic m_step(input bit vld, input bit b);
    e_wr_en = 0; e_flag = 0; e_abort = 0; e_end = 0;
    if (!vld) return;
    if (b) begin
      if (m_ones == 6 && m_in) begin e_abort = 1; m_in = 0; end
      if (m_ones < 5) m_emit(1);
      if (m_ones < 7) m_ones++;
    end else begin
      if (m_ones == 6) m_flag();
      else if (m_ones < 5) m_emit(0);
      m_ones = 0;
    end
  endtask

  // one clock: drive at negedge, model, compare at the next negedge
  task automatic cycle(input bit b, input bit vld);
    bit_vld = vld;
    bit_in  = b;
    m_step(vld, b);
    @(negedge clk);
    chk("R4", "wr_en", wr_en, e_wr_en);
    chk("R4", "wr_addr", wr_addr, e_addr);
    chk("R4", "wr_data", wr_data, e_data);
    chk("R2", "flag_seen", flag_seen, e_flag);
    chk("R7", "abort_seen", abort_seen, e_abort);
    chk("R8", "msg_end", msg_end, e_end);
    chk("R6", "fcs_err", fcs_err, e_fcs);
    chk("R10", "msg_len", msg_len, e_len);
    chk("R9", "cr_bit", cr_bit, e_cr);
    chk("R9", "msg_type", msg_type, e_type);
    if (wr_en) begin
      mem[wr_addr] = wr_data; wr_total++; last_wr_addr = wr_addr;
    end
    if (msg_end) eom_total++;
    if (abort_seen) abort_total++;
    if (flag_seen) flag_total++;
  endtask

  // strobed bit with a periodic idle cycle carrying a garbage value (R1)
  task automatic send_bit(input bit b);
    gap_ctr++;
    if (gap_ctr % 5 == 0) cycle(~b, 1'b0);
    cycle(b, 1'b1);
  endtask

  task automatic send_flag();
    send_bit(0);
    for (int i = 0; i < 6; i++) send_bit(1);
    send_bit(0);
    tx_ones = 0;
  endtask

  task automatic send_data_bit(input bit b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_bit(0); tx_ones = 0; end
    end else begin
      tx_ones = 0;
    end
  endtask

  task automatic send_octet(input bit [7:0] v);
    for (int i = 0; i < 8; i++) send_data_bit(v[i]);
  endtask

  task automatic send_frame(input bit [7:0] q[$], input bit corrupt);
    bit [15:0] c;
    bit [15:0] f;
    c = 16'hFFFF;
    foreach (q[k]) begin
      for (int i = 0; i < 8; i++) c = crc_step(c, q[k][i]);
      send_octet(q[k]);
    end
    f = ~c;
    if (corrupt) f[3] = ~f[3];
    send_octet(f[7:0]);
    send_octet(f[15:8]);
  endtask

  initial begin
    bit [7:0] fa[$];
    bit [7:0] fb[$];
    bit [7:0] fc[$];
    bit [7:0] big[$];
    int w0, e0, a0, f0;
    m_ones = 0; m_in = 0; m_stored = 0; m_nb = 0; m_crc = 16'hFFFF;
    e_addr = 0; e_data = 0; e_len = 0; e_type = 0; e_fcs = 0; e_cr = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "outputs in reset",
        {wr_en, wr_addr, wr_data, flag_seen, abort_seen, msg_end, fcs_err, cr_bit, msg_type, msg_len}, 0);
    rst = 1'b0;

    // idle ones while hunting: no abort (R7)
    for (int i = 0; i < 12; i++) send_bit(1);
    chk("R7", "abort while hunting", abort_total, 0);

    // frame A, then frame B sharing one flag (bad check field)
    fa = '{8'h0E, 8'h01, 8'h03, 8'h38, 8'h5A};
    fb = '{8'hFC, 8'hFF, 8'h7E, 8'h3F};
    send_flag();
    send_frame(fa, 0);
    send_flag();
    chk("R8", "eom after frame A", eom_total, 1);
    chk("R6", "fcs_err frame A", fcs_err, 0);
    chk("R10", "len frame A", msg_len, 7);
    chk("R9", "cr frame A", cr_bit, 1);
    chk("R9", "type frame A", msg_type, 8'h38);
    chk("R4", "frame A first octet", mem[BASE], 8'h0E);
    chk("R4", "frame A fifth octet", mem[BASE + 4], 8'h5A);
    send_frame(fb, 1);
    send_flag();
    chk("R8", "eom after frame B", eom_total, 2);
    chk("R6", "fcs_err frame B", fcs_err, 1);
    chk("R4", "frame B restarts at base", mem[BASE], 8'hFC);
    chk("R3", "stuffed 0xFF", mem[BASE + 1], 8'hFF);
    chk("R3", "stuffed 0x7E", mem[BASE + 2], 8'h7E);
    chk("R9", "cr frame B", cr_bit, 0);

    // R1: strobe low, busy garbage on bit_in
    w0 = wr_total; f0 = flag_total;
    for (int i = 0; i < 40; i++) cycle(i % 8 != 0 && i % 8 != 7, 1'b0);
    chk("R1", "writes without strobe", wr_total, w0);
    chk("R1", "flags without strobe", flag_total, f0);

    // back-to-back flags: no end of message
    e0 = eom_total;
    send_flag(); send_flag(); send_flag();
    chk("R8", "idle flags", eom_total, e0);

    // abort inside a frame
    a0 = abort_total; e0 = eom_total;
    send_octet(8'h10); send_octet(8'h20);
    for (int i = 0; i < 9; i++) send_bit(1);
    chk("R7", "abort pulse count", abort_total, a0 + 1);
    send_flag();
    chk("R7", "aborted frame gives no eom", eom_total, e0);

    // short frame: one payload octet
    fc = '{8'h02};
    send_frame(fc, 0);
    send_flag();
    chk("R8", "eom short frame", eom_total, e0 + 1);
    chk("R6", "fcs short frame", fcs_err, 0);
    chk("R10", "len short frame", msg_len, 3);
    chk("R9", "type short frame", msg_type, 0);

    // non-octet frame
    e0 = eom_total;
    send_data_bit(1); send_data_bit(0); send_data_bit(1); send_data_bit(1);
    send_data_bit(0); send_data_bit(0); send_data_bit(1); send_data_bit(0);
    send_data_bit(1); send_data_bit(0); send_data_bit(0);
    send_flag();
    chk("R6", "non-octet frame flagged", fcs_err, 1);
    chk("R8", "eom non-octet", eom_total, e0 + 1);

    // window overflow
    e0 = eom_total; w0 = wr_total;
    for (int i = 0; i < 90; i++) big.push_back(8'((i * 7 + 1) & 8'hFF));
    send_frame(big, 0);
    chk("R5", "octets written before overflow", wr_total - w0, DEPTH);
    chk("R5", "last address", last_wr_addr, 'h135);
    send_flag();
    chk("R5", "no eom after overflow", eom_total, e0);
    send_frame(fa, 0);
    send_flag();
    chk("R5", "recovered frame eom", eom_total, e0 + 1);
    chk("R5", "recovered frame at base", mem[BASE], 8'h0E);
    chk("R6", "recovered frame fcs", fcs_err, 0);

    for (int i = 0; i < 10; i++) send_bit(1);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule